// File: doc/BRIEF.md
# Load Address and Byte-Extension Unit

This unit sits in the memory stage of a 32-bit load/store pipeline. For each accepted request it forms the effective address from a base register value and an offset. The offset can be an immediate, an index register, or an index register shifted left. The offset is added to or subtracted from the base. The unit also produces the updated base value that the register file may write back.

Three indexing modes are supported. Offset mode uses the adjusted address and leaves the base register alone. Pre-indexed mode uses the adjusted address and also writes it back to the base. Post-indexed mode accesses memory at the unmodified base and then writes the adjusted value back.

The aligned little-endian memory word arrives together with the request. The unit picks the byte that the effective address points at and returns it as a 32-bit value, either zero-extended or sign-extended. All results are registered and appear one cycle after the input strobe.

Top module: `ldaddr_unit`

## Requirements
- R1: With `amode` = 0 (offset), `eff_addr` equals the base adjusted by the offset and `wb_en` is 0.
- R2: With `amode` = 1 (pre-indexed), `eff_addr` equals the adjusted base, `wb_data` carries that same value, and `wb_en` is 1.
- R3: With `amode` = 2 (post-indexed), `eff_addr` equals the unmodified base, `wb_data` carries the adjusted base, and `wb_en` is 1.
- R4: `off_src` picks the offset: 0 selects `imm` zero-extended to 32 bits, 1 selects `idx`, and 2 or 3 select `idx` shifted left by `shamt`.
- R5: `sub_sel` = 0 adds the offset to the base; `sub_sel` = 1 subtracts it. `wb_data` always carries this adjusted base.
- R6: With `sext` = 0, `ld_data[7:0]` holds the selected byte and `ld_data[31:8]` is zero.
- R7: With `sext` = 1, `ld_data[7:0]` holds the selected byte and `ld_data[31:8]` repeats bit 7 of that byte.
- R8: The selected byte is lane `eff_addr[1:0]` of `mem_word`, where lane k is bits 8k+7:8k. Lane 0 (bits 7:0) is the lowest address.
- R9: Address arithmetic wraps modulo 2^32 with no other indication.
- R10: Outputs are zero and `out_valid` is 0 after reset. `out_valid` is 1 exactly one cycle after `in_valid`. Data outputs hold their last value while no request arrives.
- R11: `amode` = 3 behaves like offset mode: the adjusted address is used and `wb_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| base | input | 32 | Base register value |
| imm | input | 12 | Immediate offset |
| idx | input | 32 | Index register value |
| shamt | input | 2 | Left shift applied to the index |
| off_src | input | 2 | Offset source select |
| sub_sel | input | 1 | 1 = subtract offset |
| amode | input | 2 | Indexing mode |
| sext | input | 1 | 1 = sign-extend loaded byte |
| mem_word | input | 32 | Aligned little-endian memory word |
| out_valid | output | 1 | Results valid |
| eff_addr | output | 32 | Effective address |
| wb_data | output | 32 | Updated base value |
| wb_en | output | 1 | Base writeback enable |
| ld_data | output | 32 | Extended byte load result |

## Verification
Address formation and byte-lane extraction resolve in the same cycle. The lane comes from the low bits of the address being computed in that cycle. In post-indexed mode the lane follows the base, while the written-back value follows the adjusted base.

The bench provokes this with unaligned bases, and with offsets that move the low address bits across lanes and across the 32-bit wrap. It sends these as back-to-back strobes with mixed modes. A scoreboard computes the expected address, writeback and extended byte from the requirements and compares each registered result as it appears.

// File: rtl/ldaddr_pkg.sv
package ldaddr_pkg;
   typedef enum logic [1:0] {
      AM_OFFSET = 2'd0,
      AM_PRE    = 2'd1,
      AM_POST   = 2'd2,
      AM_RSVD   = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      OS_IMM     = 2'd0,
      OS_REG     = 2'd1,
      OS_REG_SHL = 2'd2,
      OS_RSVD    = 2'd3
   } osrc_e;
endpackage

// File: rtl/ldaddr_offset.sv
module ldaddr_offset #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 12,
   parameter int SH_W  = 2
) (
   input  logic [IMM_W-1:0] imm,
   input  logic [XLEN-1:0]  idx,
   input  logic [SH_W-1:0]  shamt,
   input  logic [1:0]       src,
   output logic [XLEN-1:0]  off
);
   import ldaddr_pkg::*;

   logic [XLEN-1:0] imm_ext;

   generate
      if (IMM_W < XLEN) begin : g_pad
         assign imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};
      end else begin : g_full
         assign imm_ext = imm[XLEN-1:0];
      end
   endgenerate

   always_comb begin
      case (osrc_e'(src))
         OS_IMM:  off = imm_ext;
         OS_REG:  off = idx;
         default: off = idx << shamt;
      endcase
   end
endmodule

// File: rtl/ldaddr_agen.sv
module ldaddr_agen #(
   parameter int XLEN       = 32,
   parameter bit ONE_ADDER  = 1'b1
) (
   input  logic [XLEN-1:0] base,
   input  logic [XLEN-1:0] off,
   input  logic            sub_sel,
   input  logic [1:0]      amode,
   output logic [XLEN-1:0] eff,
   output logic [XLEN-1:0] upd,
   output logic            wb_en
);
   import ldaddr_pkg::*;

   generate
      if (ONE_ADDER) begin : g_one
         logic [XLEN-1:0] opnd;
         assign opnd = off ^ {XLEN{sub_sel}};
         assign upd  = base + opnd + {{(XLEN-1){1'b0}}, sub_sel};
      end else begin : g_two
         assign upd = sub_sel ? (base - off) : (base + off);
      end
   endgenerate

   always_comb begin
      case (amode_e'(amode))
         AM_PRE: begin
            eff   = upd;
            wb_en = 1'b1;
         end
         AM_POST: begin
            eff   = base;
            wb_en = 1'b1;
         end
         default: begin
            eff   = upd;
            wb_en = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/ldaddr_bytefmt.sv
module ldaddr_bytefmt #(
   parameter int XLEN = 32,
   localparam int LANES = XLEN / 8,
   localparam int LB    = $clog2(LANES)
) (
   input  logic [XLEN-1:0] word,
   input  logic [LB-1:0]   lane_sel,
   input  logic            sext,
   output logic [XLEN-1:0] result
);
   logic [7:0] lanes [LANES];
   logic [7:0] pick;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         assign lanes[g] = word[g*8 +: 8];
      end
   endgenerate

   assign pick   = lanes[lane_sel];
   assign result = {{(XLEN-8){sext & pick[7]}}, pick};
endmodule

// File: rtl/ldaddr_unit.sv
module ldaddr_unit #(
   parameter int XLEN      = 32,
   parameter int IMM_W     = 12,
   parameter int SH_W      = 2,
   parameter bit ONE_ADDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [XLEN-1:0]  base,
   input  logic [IMM_W-1:0] imm,
   input  logic [XLEN-1:0]  idx,
   input  logic [SH_W-1:0]  shamt,
   input  logic [1:0]       off_src,
   input  logic             sub_sel,
   input  logic [1:0]       amode,
   input  logic             sext,
   input  logic [XLEN-1:0]  mem_word,
   output logic             out_valid,
   output logic [XLEN-1:0]  eff_addr,
   output logic [XLEN-1:0]  wb_data,
   output logic             wb_en,
   output logic [XLEN-1:0]  ld_data
);
   localparam int LANES = XLEN / 8;
   localparam int LB    = $clog2(LANES);

   generate
      if ((XLEN % 8) != 0 || XLEN < 16) begin : g_bad_xlen
         $error("XLEN must be a multiple of 8 and at least 16");
      end
      if (IMM_W < 1 || IMM_W > XLEN) begin : g_bad_imm
         $error("IMM_W must lie in 1..XLEN");
      end
      if (SH_W < 1 || SH_W > $clog2(XLEN)) begin : g_bad_sh
         $error("SH_W out of range");
      end
   endgenerate

   logic [XLEN-1:0] off_w, eff_w, upd_w, ld_w;
   logic            wbe_w;

   ldaddr_offset #(.XLEN(XLEN), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
      .imm   (imm),
      .idx   (idx),
      .shamt (shamt),
      .src   (off_src),
      .off   (off_w)
   );

   ldaddr_agen #(.XLEN(XLEN), .ONE_ADDER(ONE_ADDER)) u_agen (
      .base    (base),
      .off     (off_w),
      .sub_sel (sub_sel),
      .amode   (amode),
      .eff     (eff_w),
      .upd     (upd_w),
      .wb_en   (wbe_w)
   );

   ldaddr_bytefmt #(.XLEN(XLEN)) u_fmt (
      .word     (mem_word),
      .lane_sel (eff_w[LB-1:0]),
      .sext     (sext),
      .result   (ld_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         eff_addr  <= '0;
         wb_data   <= '0;
         wb_en     <= 1'b0;
         ld_data   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            eff_addr <= eff_w;
            wb_data  <= upd_w;
            wb_en    <= wbe_w;
            ld_data  <= ld_w;
         end
      end
   end
endmodule

// File: rtl/ldaddr_unit_chk.sv
module ldaddr_unit_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [1:0]      amode,
   input logic            sext,
   input logic [XLEN-1:0] base,
   input logic            out_valid,
   input logic [XLEN-1:0] eff_addr,
   input logic [XLEN-1:0] wb_data,
   input logic            wb_en,
   input logic [XLEN-1:0] ld_data
);
   assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid))
      else $error("out_valid does not follow in_valid");

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(eff_addr) && $stable(ld_data))
      else $error("outputs changed without a request");

   assert_pre_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(amode) == 2'd1 |-> eff_addr == wb_data && wb_en)
      else $error("pre-indexed address differs from writeback");

   assert_post_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(amode) == 2'd2 |-> eff_addr == $past(base) && wb_en)
      else $error("post-indexed address is not the base");

   assert_no_wb_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && ($past(amode) == 2'd0 || $past(amode) == 2'd3) |-> !wb_en)
      else $error("writeback in offset mode");

   assert_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !$past(sext) |-> ld_data[XLEN-1:8] == '0)
      else $error("unsigned load upper bits not clear");

   assert_sign_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(sext) |-> ld_data[XLEN-1:8] == {(XLEN-8){ld_data[7]}})
      else $error("signed load upper bits not a copy of bit 7");
endmodule

bind ldaddr_unit ldaddr_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .amode     (amode),
   .sext      (sext),
   .base      (base),
   .out_valid (out_valid),
   .eff_addr  (eff_addr),
   .wb_data   (wb_data),
   .wb_en     (wb_en),
   .ld_data   (ld_data)
);

// File: tb/ldaddr_unit_test.sv
module ldaddr_unit_test;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] base = '0;
   logic [11:0] imm = '0;
   logic [31:0] idx = '0;
   logic [1:0]  shamt = '0;
   logic [1:0]  off_src = '0;
   logic        sub_sel = 1'b0;
   logic [1:0]  amode = '0;
   logic        sext = 1'b0;
   logic [31:0] mem_word = '0;
   logic        out_valid;
   logic [31:0] eff_addr, wb_data, ld_data;
   logic        wb_en;

   int errors = 0;
   int checks = 0;

   typedef struct {
      logic [31:0] ea;
      logic [31:0] wb;
      logic        wbe;
      logic [31:0] ld;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [31:0] last_ea;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldaddr_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base(base), .imm(imm),
      .idx(idx), .shamt(shamt), .off_src(off_src), .sub_sel(sub_sel),
      .amode(amode), .sext(sext), .mem_word(mem_word), .out_valid(out_valid),
      .eff_addr(eff_addr), .wb_data(wb_data), .wb_en(wb_en), .ld_data(ld_data)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: computes expected values from the requirements and pushes them.
   task automatic send(input logic [1:0] m, input logic [1:0] os, input logic sb_sub,
                       input logic sx, input logic [31:0] b, input logic [11:0] im,
                       input logic [31:0] ix, input logic [1:0] sh,
                       input logic [31:0] mw, input string tag);
      exp_t        e;
      logic [31:0] off, upd;
      logic [7:0]  byt;
      // R4 offset source
      if (os == 2'd0)      off = {20'd0, im};
      else if (os == 2'd1) off = ix;
      else                 off = ix << sh;
      // R5 add or subtract, R9 wrap
      upd  = sb_sub ? b - off : b + off;
      e.wb = upd;
      // R1 R2 R3 R11
      e.ea  = (m == 2'd2) ? b : upd;
      e.wbe = (m == 2'd1) || (m == 2'd2);
      // R8 lane, R6 R7 extension
      byt  = mw[8*e.ea[1:0] +: 8];
      e.ld = sx ? {{24{byt[7]}}, byt} : {24'd0, byt};
      e.tag = tag;
      last_ea = e.ea;
      sb.push_back(e);
      base = b; imm = im; idx = ix; shamt = sh; off_src = os; sub_sel = sb_sub;
      amode = m; sext = sx; mem_word = mw; in_valid = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops and compares as results appear.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R10 unexpected out_valid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(eff_addr == e.ea, {e.tag, " eff_addr"}, eff_addr, e.ea);
            check(wb_data == e.wb, {e.tag, " wb_data"}, wb_data, e.wb);
            check(wb_en == e.wbe, {e.tag, " wb_en"}, {31'd0, wb_en}, {31'd0, e.wbe});
            check(ld_data == e.ld, {e.tag, " ld_data"}, ld_data, e.ld);
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(out_valid == 1'b0, "R10 reset out_valid", {31'd0, out_valid}, 32'd0);
      check(eff_addr == 32'd0, "R10 reset eff_addr", eff_addr, 32'd0);
      check(ld_data == 32'd0 && wb_en == 1'b0, "R10 reset ld_data", ld_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R4 R8: offset mode, immediate, lane 0
      send(2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_1000, 12'h010, 32'h0, 2'd0, 32'h4433_2211, "R1 R4 R8 imm lane0");
      idle(2);
      // R2 R5 R4: pre-indexed subtract index register, lane 1, signed positive
      send(2'd1, 2'd1, 1'b1, 1'b1, 32'h0000_2003, 12'h0, 32'd2, 2'd0, 32'h12C3_7F78, "R2 R5 R7 pre sub");
      // R3 R4: post-indexed shifted index, lane from base
      send(2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_3002, 12'h0, 32'd1, 2'd3, 32'hA1B2_C3D4, "R3 R4 R6 post shl");
      // R9 wrap upward and downward
      send(2'd0, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFE, 12'h005, 32'h0, 2'd0, 32'h8070_6050, "R9 wrap add lane3");
      send(2'd1, 2'd1, 1'b1, 1'b0, 32'h0000_0001, 12'h0, 32'd2, 2'd0, 32'hFE00_0000, "R9 wrap sub");
      // R7 R6 negative byte both ways
      send(2'd0, 2'd0, 1'b0, 1'b1, 32'h0000_4000, 12'h002, 32'h0, 2'd0, 32'h0080_0000, "R7 sign negative");
      send(2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_4000, 12'h002, 32'h0, 2'd0, 32'h0080_0000, "R6 zero negative");
      // R11 reserved mode, R4 code 3
      send(2'd3, 2'd3, 1'b0, 1'b1, 32'h0000_5000, 12'h0, 32'd1, 2'd1, 32'h0102_F304, "R11 mode3 no wb");
      // R8 post-indexed lane follows base, not updated value
      send(2'd2, 2'd0, 1'b0, 1'b1, 32'h0000_6001, 12'h002, 32'h0, 2'd0, 32'h11FF_8822, "R8 R3 post lane");
      idle(4);
      // R10 hold while idle
      check(out_valid == 1'b0, "R10 idle out_valid", {31'd0, out_valid}, 32'd0);
      check(eff_addr == last_ea, "R10 hold eff_addr", eff_addr, last_ea);

      // Mixed back-to-back stream
      for (int i = 0; i < 40; i++) begin
         send(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), $urandom,
              12'($urandom), $urandom, 2'($urandom), $urandom, "R1 R2 R3 R5 R8 stream");
         if (i % 7 == 6) idle(1);
      end
      idle(3);
      check(sb.size() == 0, "R10 all results seen", sb.size(), 32'd0);
      finish_run();
   end
endmodule